// File: doc/BRIEF.md
# Planar Graphics Write/Read Datapath

This block sits between an 8-bit CPU data bus and four 8-bit memory planes that share one address. Every CPU read captures all four plane bytes into hidden latches. The byte returned to the CPU is either one selected plane or a colour-match bitmap. In the bitmap, each of the eight pixel positions reports whether the 4-bit value it builds across the planes equals a programmed colour. Planes marked as don't-care are left out of that comparison.

A CPU write runs in three steps. The byte is rotated right. Selected planes then have it replaced by a constant all-ones or all-zeros byte. Each plane's result is then combined with that plane's latch by pass, AND, OR or XOR. The block emits four plane bytes and a per-plane write enable taken from a map mask.

Eight configuration registers are reached through an index register and a data port. Address generation and display fetch are outside the block.

Top module: `planar_gfx_datapath`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all configuration registers, the index, the four latches, `cpu_rdata`, `mem_wdata` and `mem_we` are zero.
- R2: A cycle with `cpu_rd` high loads latch p from `mem_rdata[8p+7:8p]` at that clock edge. The `cpu_rdata` produced by that read appears on the following cycle.
- R3: With read-mode bit (register 5 bit 3) clear, a read returns the byte of the plane numbered by register 4 bits 1:0.
- R4: With read-mode bit set, bit i of the returned byte is 1 when, for every plane p whose don't-care bit (register 6 bit p) is 1, plane p's bit i equals colour-compare bit p (register 2 bit p). When register 6 is zero the result is 0xFF.
- R5: In write mode 0, the CPU byte is rotated right by register 3 bits 2:0 before any other step.
- R6: In write mode 0, a plane whose enable bit (register 1 bit p) is set uses 0xFF when set/reset bit p (register 0 bit p) is 1 and 0x00 when it is 0, in place of the rotated byte.
- R7: Register 3 bits 4:3 select the last step against that plane's latch: 0 passes the value, 1 ANDs, 2 ORs, 3 XORs. This step comes after rotation and substitution.
- R8: The cycle after a write, `mem_we` equals the map mask (register 7 bits 3:0) and `mem_wdata` carries the four results, plane p at bits 8p+7:8p. On any cycle not following a write, `mem_we` is zero and `mem_wdata` holds its value.
- R9: When the write-mode field (register 5 bits 1:0) is non-zero, a write still updates `mem_wdata` but leaves `mem_we` zero.
- R10: `cfg_we` with `cfg_is_index` high loads the index from `cfg_wdata[2:0]`. `cfg_we` with `cfg_is_index` low writes `cfg_wdata` into the indexed register, and the value takes effect on the next cycle.
- R11: `cpu_rdata` changes only on the cycle after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_index | input | 1 | Selects index (1) or data (0) for a configuration write |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_rd | input | 1 | CPU read strobe, memory data valid this cycle |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| mem_rdata | input | 32 | Four plane bytes read from memory |
| cpu_rdata | output | 8 | Registered CPU read result |
| mem_wdata | output | 32 | Registered four plane write bytes |
| mem_we | output | 4 | Registered per-plane write enables |

## Verification
The hardest case to reach is a write whose result depends on every stage at once. That means a non-zero rotation, a mix of substituted and passed-through planes, and a logic function combining them with latch contents left by an earlier read. The stimulus first performs reads that leave distinct values in each latch. It then reprograms rotation, set/reset, function and mask between writes. A behavioural model recomputes every output on every cycle, so a latch captured at the wrong time shows up in a later write result. The same holds for a stage applied in the wrong order.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  localparam int DW   = 8;
  localparam int NPL  = 4;
  localparam int IW   = 3;
  localparam int NREG = 1 << IW;
  localparam int SELW = $clog2(NPL);
  localparam int RSHW = $clog2(DW);

  localparam logic [IW-1:0] IX_SETRST = 3'd0;
  localparam logic [IW-1:0] IX_SREN   = 3'd1;
  localparam logic [IW-1:0] IX_CCOLOR = 3'd2;
  localparam logic [IW-1:0] IX_ROTFN  = 3'd3;
  localparam logic [IW-1:0] IX_RDSEL  = 3'd4;
  localparam logic [IW-1:0] IX_MODE   = 3'd5;
  localparam logic [IW-1:0] IX_DCARE  = 3'd6;
  localparam logic [IW-1:0] IX_MASK   = 3'd7;

  typedef enum logic [1:0] {FN_PASS, FN_AND, FN_OR, FN_XOR} fn_e;

  function automatic logic [DW-1:0] rot_right(input logic [DW-1:0] d,
                                               input logic [RSHW-1:0] n);
    logic [2*DW-1:0] t;
    t = {d, d} >> n;
    return t[DW-1:0];
  endfunction
endpackage

// File: rtl/gfx_regfile.sv
module gfx_regfile
  import gfx_pkg::*;
#(
  parameter int W  = DW,
  parameter int AW = IW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic                          cfg_is_index,
  input  logic [W-1:0]                  cfg_wdata,
  output logic [(1<<AW)-1:0][W-1:0]     regs
);
  localparam int N = 1 << AW;
  logic [AW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      regs <= '0;
    end else if (cfg_we) begin
      if (cfg_is_index) idx <= cfg_wdata[AW-1:0];
      else              regs[idx] <= cfg_wdata;
    end
  end

  a_r10_index: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_is_index) |=> (idx == $past(cfg_wdata[AW-1:0])));
  a_r10_data: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_is_index) |=> (regs[$past(idx)] == $past(cfg_wdata)));
endmodule

// File: rtl/gfx_read_path.sv
module gfx_read_path
  import gfx_pkg::*;
#(
  parameter int W = DW,
  parameter int P = NPL
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_rd,
  input  logic [P*W-1:0]          mem_rdata,
  input  logic                    rd_mode,
  input  logic [$clog2(P)-1:0]    rd_sel,
  input  logic [P-1:0]            cc_color,
  input  logic [P-1:0]            cc_care,
  output logic [P-1:0][W-1:0]     latch_q,
  output logic [W-1:0]            cpu_rdata
);
  logic [P-1:0][W-1:0] planes;
  logic [W-1:0]        cmp_bits;
  logic [W-1:0]        rd_next;

  assign planes = mem_rdata;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      cmp_bits[i] = 1'b1;
      for (int p = 0; p < P; p++)
        if (cc_care[p] && (planes[p][i] != cc_color[p])) cmp_bits[i] = 1'b0;
    end
    rd_next = rd_mode ? cmp_bits : planes[rd_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '0;
      cpu_rdata <= '0;
    end else if (cpu_rd) begin
      latch_q   <= planes;
      cpu_rdata <= rd_next;
    end
  end

  a_r2_latch_load: assert property (@(posedge clk) disable iff (rst)
    cpu_rd |=> (latch_q == $past(mem_rdata)));
  a_r4_no_care_all_ones: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && rd_mode && (cc_care == '0)) |=> (cpu_rdata == '1));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));
endmodule

// File: rtl/gfx_write_path.sv
module gfx_write_path
  import gfx_pkg::*;
#(
  parameter int W = DW,
  parameter int P = NPL
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_wr,
  input  logic [W-1:0]            cpu_wdata,
  input  logic [P-1:0][W-1:0]     latch_q,
  input  logic [P-1:0]            setrst,
  input  logic [P-1:0]            sr_en,
  input  logic [RSHW-1:0]         rot,
  input  fn_e                     fn,
  input  logic [1:0]              wmode,
  input  logic [P-1:0]            mask,
  output logic [P-1:0][W-1:0]     mem_wdata,
  output logic [P-1:0]            mem_we
);
  logic [W-1:0]        rotated;
  logic [P-1:0][W-1:0] result;

  assign rotated = rot_right(cpu_wdata, rot);

  for (genvar p = 0; p < P; p++) begin : g_plane
    logic [W-1:0] src;
    assign src = sr_en[p] ? {W{setrst[p]}} : rotated;
    always_comb begin
      unique case (fn)
        FN_AND:  result[p] = src & latch_q[p];
        FN_OR:   result[p] = src | latch_q[p];
        FN_XOR:  result[p] = src ^ latch_q[p];
        default: result[p] = src;
      endcase
    end

    a_r6_setrst: assert property (@(posedge clk) disable iff (rst)
      (cpu_wr && (fn == FN_PASS) && sr_en[p]) |=>
        (mem_wdata[p] == {W{$past(setrst[p])}}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wdata <= '0;
      mem_we    <= '0;
    end else begin
      mem_we <= (cpu_wr && (wmode == 2'd0)) ? mask : '0;
      if (cpu_wr) mem_wdata <= result;
    end
  end

  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    ((mem_we & ~$past(mask)) == '0));
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |=> (mem_we == '0));
  a_r9_mode: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && (wmode != 2'd0)) |=> (mem_we == '0));
endmodule

// File: rtl/planar_gfx_datapath.sv
module planar_gfx_datapath
  import gfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_is_index,
  input  logic [DW-1:0]      cfg_wdata,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic [NPL*DW-1:0]  mem_rdata,
  output logic [DW-1:0]      cpu_rdata,
  output logic [NPL*DW-1:0]  mem_wdata,
  output logic [NPL-1:0]     mem_we
);
  logic [NREG-1:0][DW-1:0] regs;
  logic [NPL-1:0][DW-1:0]  latch_q;
  logic [NPL-1:0][DW-1:0]  wdata_p;
  fn_e                     fn;

  gfx_regfile #(.W(DW), .AW(IW)) u_regs (
    .clk, .rst, .cfg_we, .cfg_is_index, .cfg_wdata, .regs
  );

  gfx_read_path #(.W(DW), .P(NPL)) u_rd (
    .clk, .rst, .cpu_rd, .mem_rdata,
    .rd_mode  (regs[IX_MODE][3]),
    .rd_sel   (regs[IX_RDSEL][SELW-1:0]),
    .cc_color (regs[IX_CCOLOR][NPL-1:0]),
    .cc_care  (regs[IX_DCARE][NPL-1:0]),
    .latch_q,
    .cpu_rdata
  );

  assign fn = fn_e'(regs[IX_ROTFN][4:3]);

  gfx_write_path #(.W(DW), .P(NPL)) u_wr (
    .clk, .rst, .cpu_wr, .cpu_wdata, .latch_q,
    .setrst    (regs[IX_SETRST][NPL-1:0]),
    .sr_en     (regs[IX_SREN][NPL-1:0]),
    .rot       (regs[IX_ROTFN][RSHW-1:0]),
    .fn,
    .wmode     (regs[IX_MODE][1:0]),
    .mask      (regs[IX_MASK][NPL-1:0]),
    .mem_wdata (wdata_p),
    .mem_we
  );

  assign mem_wdata = wdata_p;

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (mem_we == '0 && cpu_rdata == '0 && mem_wdata == '0));
endmodule

// File: tb/planar_gfx_datapath_tb.sv
`timescale 1ns/1ps
module planar_gfx_datapath_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0, cfg_is_index = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        cpu_rd = 0, cpu_wr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic [31:0] mem_rdata = 0;
  logic [7:0]  cpu_rdata;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_we;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  planar_gfx_datapath u_dut (.*);

  // behavioural reference
  logic [7:0] m_reg [8];
  logic [2:0] m_idx;
  logic [7:0] m_lat [4];
  logic [7:0] m_rdata;
  logic [7:0] m_wd [4];
  logic [3:0] m_we;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) m_reg[i] = 0;
      for (int p = 0; p < 4; p++) begin m_lat[p] = 0; m_wd[p] = 0; end
      m_idx = 0; m_rdata = 0; m_we = 0;
    end else begin
      m_we = 0;
      if (cpu_wr) begin
        int r;
        logic [7:0] rb, v;
        r = m_reg[3] % 8;
        rb = 8'((int'(cpu_wdata) >> r) | (int'(cpu_wdata) << (8 - r)));
        for (int p = 0; p < 4; p++) begin
          v = m_reg[1][p] ? (m_reg[0][p] ? 8'hFF : 8'h00) : rb;
          case ((m_reg[3] >> 3) % 4)
            1: v = v & m_lat[p];
            2: v = v | m_lat[p];
            3: v = v ^ m_lat[p];
            default: ;
          endcase
          m_wd[p] = v;
        end
        if (m_reg[5] % 4 == 0) m_we = m_reg[7][3:0];
      end
      if (cpu_rd) begin
        for (int p = 0; p < 4; p++) m_lat[p] = mem_rdata[p*8 +: 8];
        if (m_reg[5][3]) begin
          for (int i = 0; i < 8; i++) begin
            bit ok;
            ok = 1;
            for (int p = 0; p < 4; p++)
              if (m_reg[6][p] && (m_lat[p][i] != m_reg[2][p])) ok = 0;
            m_rdata[i] = ok;
          end
        end else m_rdata = m_lat[m_reg[4] % 4];
      end
      if (cfg_we) begin
        if (cfg_is_index) m_idx = cfg_wdata[2:0];
        else m_reg[m_idx] = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (cpu_rdata !== m_rdata) begin
      errors++;
      $display("FAIL %s cpu_rdata actual %h expected %h", cur_req, cpu_rdata, m_rdata);
    end
    checks++;
    if (mem_we !== m_we) begin
      errors++;
      $display("FAIL %s mem_we actual %h expected %h", cur_req, mem_we, m_we);
    end
    checks++;
    if (mem_wdata !== {m_wd[3], m_wd[2], m_wd[1], m_wd[0]}) begin
      errors++;
      $display("FAIL %s mem_wdata actual %h expected %h", cur_req, mem_wdata,
               {m_wd[3], m_wd[2], m_wd[1], m_wd[0]});
    end
  end

  task automatic cfg(input logic [2:0] ix, input logic [7:0] val);
    @(negedge clk); cfg_we = 1; cfg_is_index = 1; cfg_wdata = {5'd0, ix};
    @(negedge clk); cfg_is_index = 0; cfg_wdata = val;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [31:0] d);
    @(negedge clk); cpu_rd = 1; mem_rdata = d;
    @(negedge clk); cpu_rd = 0; mem_rdata = $urandom;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0; cpu_wdata = $urandom;
    @(negedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    cur_req = "R10";
    cfg(3'd7, 8'h0F);
    cfg(3'd4, 8'h02);

    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      cfg(3'd4, 8'(s));
      rd($urandom);
    end

    cur_req = "R2";
    rd(32'h81C3_5A0F);
    rd(32'hFFFF_0000);

    cur_req = "R4";
    cfg(3'd5, 8'h08);
    cfg(3'd6, 8'h00);
    rd($urandom);
    for (int k = 0; k < 12; k++) begin
      cfg(3'd2, 8'($urandom));
      cfg(3'd6, 8'($urandom));
      rd($urandom);
    end
    cfg(3'd6, 8'h0F); cfg(3'd2, 8'h05);
    rd(32'hFF00_FF00);
    cfg(3'd5, 8'h00);

    cur_req = "R11";
    repeat (6) @(negedge clk);

    cur_req = "R5";
    cfg(3'd1, 8'h00);
    for (int r = 0; r < 8; r++) begin
      cfg(3'd3, 8'(r));
      wr(8'h96);
      wr(8'h01);
    end

    cur_req = "R6";
    cfg(3'd3, 8'h03);
    for (int k = 0; k < 6; k++) begin
      cfg(3'd0, 8'($urandom));
      cfg(3'd1, 8'($urandom));
      wr($urandom);
    end

    cur_req = "R7";
    rd(32'hA5_3C_F0_0F);
    for (int f = 0; f < 4; f++) begin
      cfg(3'd3, 8'((f << 3) | 5));
      cfg(3'd1, 8'h05); cfg(3'd0, 8'h04);
      wr(8'hC6);
      wr(8'h3B);
    end

    cur_req = "R8";
    for (int m = 0; m < 16; m += 3) begin
      cfg(3'd7, 8'(m));
      rd($urandom);
      wr($urandom);
    end

    cur_req = "R9";
    cfg(3'd7, 8'h0F);
    for (int w = 1; w < 4; w++) begin
      cfg(3'd5, 8'(w));
      wr($urandom);
    end
    cfg(3'd5, 8'h00);

    cur_req = "R2";
    @(negedge clk); cpu_rd = 1; cpu_wr = 1; mem_rdata = $urandom; cpu_wdata = $urandom;
    @(negedge clk); cpu_rd = 0; cpu_wr = 0;
    wr(8'h55);
    repeat (3) @(negedge clk);

    cur_req = "R1";
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule